// File: doc/BRIEF.md
# Write-Once Option Register Pair

This block holds two 8-bit option registers on a small peripheral bus. Software sets each register by writing to its address, and only the first write after a reset counts. Later writes to that register are dropped until the next reset. The latched option bits drive dedicated outputs, which set up clocking, stop-mode behaviour, the watchdog and the low-voltage monitor elsewhere on the chip.

Register 1 has one bit with its own rule: the low-voltage select bit. Only a power-on reset clears it, and it takes a single write per power-on. It has a separate lock, so an ordinary reset neither clears it nor lets software write it again. Register 2 stores four option bits. Its other positions are not stored and always read as zero.

The block has two asynchronous active-low reset inputs, and both are released synchronously inside the block. The power-on reset clears everything. The ordinary reset clears everything except the low-voltage select bit and its lock.

Top module: `cfg_once_regs`

## Requirements
- R1: After a power-on reset, every option output reads 0, and reads of address 0x1F and 0x1E both return 0.
- R2: The first write strobe to address 0x1F after a reset stores all eight bits of register 1. Readback at 0x1F and the option outputs show the stored bits from the cycle after the write. The bit positions, from bit 7 down to bit 0, are: watchdog rate, monitor-on-in-stop, monitor reset off, monitor power off, low-voltage select, short stop recovery, stop allowed, watchdog off.
- R3: The first write strobe to address 0x1E after a reset stores bits 6 (crystal enable), 5 (slow external clock), 4 (external clock enable) and 1 (oscillator kept in stop). Bits 7, 3, 2 and 0 always read 0 at 0x1E.
- R4: Once a register has taken its write, later writes to its address leave its readback and its outputs unchanged until the next reset.
- R5: An ordinary reset clears all register 1 bits except bit 3, and all register 2 bits. It also re-arms the general write of both registers.
- R6: Bit 3 of register 1 accepts one write per power-on reset. An ordinary reset neither clears it nor re-arms it. If bit 3 has not yet been written since power-on, it is still writable after an ordinary reset.
- R7: A power-on reset clears bit 3 of register 1 and re-arms its write.
- R8: Reads of any address other than 0x1E and 0x1F return 0. Presenting an address without a write strobe changes no state and does not use up a register's write.
- R9: The pin-release output is 1 exactly when the crystal enable bit (register 2 bit 6) is 0.
- R10: A write strobe to any address other than 0x1E and 0x1F changes neither register and does not lock either one.
- R11: Asserting either reset input clears the affected option outputs at once, with no clock edge needed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus and register clock |
| por_n | input | 1 | Power-on reset, asynchronous, active low |
| rst_n | input | 1 | Ordinary reset, asynchronous, active low |
| bus_addr | input | 8 | Bus address for reads and writes |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr, combinational |
| wdog_rate | output | 1 | Watchdog rate select (register 1 bit 7) |
| lv_in_stop | output | 1 | Low-voltage monitor kept on in stop (register 1 bit 6) |
| lv_rst_off | output | 1 | Low-voltage reset disabled (register 1 bit 5) |
| lv_pwr_off | output | 1 | Low-voltage monitor powered down (register 1 bit 4) |
| lv_sel | output | 1 | Low-voltage trip select, power-on domain (register 1 bit 3) |
| quick_stop_rec | output | 1 | Short stop recovery (register 1 bit 2) |
| stop_ok | output | 1 | Stop instruction allowed (register 1 bit 1) |
| wdog_off | output | 1 | Watchdog disabled (register 1 bit 0) |
| xtal_en | output | 1 | External crystal enable (register 2 bit 6) |
| ext_slow | output | 1 | Slow external clock range (register 2 bit 5) |
| ext_clk_en | output | 1 | External clock enable (register 2 bit 4) |
| osc_in_stop | output | 1 | Oscillator kept running in stop (register 2 bit 1) |
| osc2_gpio | output | 1 | Second oscillator pin released for general I/O |

## Verification
The bench writes each of the 256 byte values to both registers, and each register's lock is tried with the bitwise complement of that value. Any bit that escapes its lock therefore shows up as a flipped bit. Between passes it alternates power-on and ordinary resets, so a bit in the wrong reset domain, or a lock re-armed by the wrong reset, appears as a mismatch in bit 3 alone. A sweep over every other address, with and without the write strobe, separates correct address decoding from decoding that aliases onto the two registers or that consumes a write on a read.

// File: rtl/cfg_once_pkg.sv
package cfg_once_pkg;
  localparam int unsigned ADDR_W = 8;
  localparam int unsigned DATA_W = 8;
  localparam int unsigned NUM_REGS = 2;

  // Index 0: register 1, index 1: register 2
  localparam logic [ADDR_W-1:0] REG1_ADDR = 8'h1F;
  localparam logic [ADDR_W-1:0] REG2_ADDR = 8'h1E;

  // Bit of register 1 living in the power-on domain
  localparam int unsigned LV_BIT = 3;

  // Bits held by the general (any-reset) write-once latch
  localparam logic [DATA_W-1:0] REG1_GEN_MASK = 8'hF7;
  localparam logic [DATA_W-1:0] REG2_GEN_MASK = 8'h72;

  // Register 2 field positions
  localparam int unsigned XTAL_BIT = 6;
  localparam int unsigned SLOW_BIT = 5;
  localparam int unsigned EXTC_BIT = 4;
  localparam int unsigned OSCS_BIT = 1;

  localparam logic [ADDR_W-1:0] REG_ADDR [NUM_REGS] = '{REG1_ADDR, REG2_ADDR};
  localparam logic [DATA_W-1:0] REG_MASK [NUM_REGS] = '{REG1_GEN_MASK, REG2_GEN_MASK};

  localparam int unsigned SYNC_STAGES = 2;
endpackage

// File: rtl/cfg_rst_sync.sv
module cfg_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_s
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign rst_n_s = chain_q[STAGES-1];
endmodule

// File: rtl/cfg_once_reg.sv
module cfg_once_reg #(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned WIDTH  = 8,
  parameter logic [ADDR_W-1:0] ADDR = '0,
  parameter logic [WIDTH-1:0]  MASK = '1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [WIDTH-1:0]  wr_data,
  output logic [WIDTH-1:0]  q,
  output logic              locked
);
  logic [WIDTH-1:0] val_q, val_d;
  logic             lock_q, lock_d;
  logic             hit;
  logic             load_en;

  always_comb begin
    hit     = wr_en && (wr_addr == ADDR);
    load_en = hit && !lock_q;
    val_d   = val_q;
    lock_d  = lock_q;
    if (load_en) begin
      val_d  = wr_data & MASK;
      lock_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      val_q  <= '0;
      lock_q <= 1'b0;
    end else begin
      val_q  <= val_d;
      lock_q <= lock_d;
    end
  end

  assign q      = val_q;
  assign locked = lock_q;

  // R4: a locked register keeps its value
  p_locked_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    lock_q |=> $stable(val_q));

  // R2: a strobe to this address while open closes the lock
  p_first_write_locks_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == ADDR) |=> lock_q);
endmodule

// File: rtl/cfg_por_bit.sv
module cfg_por_bit #(
  parameter int unsigned ADDR_W = 8,
  parameter logic [ADDR_W-1:0] ADDR = '0
) (
  input  logic              clk,
  input  logic              por_rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic              wr_bit,
  output logic              q,
  output logic              locked
);
  logic bit_q, bit_d;
  logic lock_q, lock_d;

  always_comb begin
    bit_d  = bit_q;
    lock_d = lock_q;
    if (wr_en && (wr_addr == ADDR) && !lock_q) begin
      bit_d  = wr_bit;
      lock_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge por_rst_n) begin
    if (!por_rst_n) begin
      bit_q  <= 1'b0;
      lock_q <= 1'b0;
    end else begin
      bit_q  <= bit_d;
      lock_q <= lock_d;
    end
  end

  assign q      = bit_q;
  assign locked = lock_q;

  // R6: once written in this power-on period the bit never moves
  p_lv_hold_r6: assert property (@(posedge clk) disable iff (!por_rst_n)
    lock_q |=> $stable(bit_q));
endmodule

// File: rtl/cfg_once_regs.sv
module cfg_once_regs
  import cfg_once_pkg::*;
(
  input  logic              clk,
  input  logic              por_n,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              wdog_rate,
  output logic              lv_in_stop,
  output logic              lv_rst_off,
  output logic              lv_pwr_off,
  output logic              lv_sel,
  output logic              quick_stop_rec,
  output logic              stop_ok,
  output logic              wdog_off,
  output logic              xtal_en,
  output logic              ext_slow,
  output logic              ext_clk_en,
  output logic              osc_in_stop,
  output logic              osc2_gpio
);
  logic sys_arst_n;
  logic por_rst_n_s;
  logic sys_rst_n_s;

  assign sys_arst_n = por_n & rst_n;

  cfg_rst_sync #(.STAGES(SYNC_STAGES)) u_por_sync (
    .clk    (clk),
    .arst_n (por_n),
    .rst_n_s(por_rst_n_s)
  );

  cfg_rst_sync #(.STAGES(SYNC_STAGES)) u_sys_sync (
    .clk    (clk),
    .arst_n (sys_arst_n),
    .rst_n_s(sys_rst_n_s)
  );

  logic [DATA_W-1:0] gen_q  [NUM_REGS];
  logic [NUM_REGS-1:0] gen_lock;

  for (genvar gi = 0; gi < NUM_REGS; gi++) begin : g_reg
    cfg_once_reg #(
      .ADDR_W(ADDR_W),
      .WIDTH (DATA_W),
      .ADDR  (REG_ADDR[gi]),
      .MASK  (REG_MASK[gi])
    ) u_reg (
      .clk    (clk),
      .rst_n  (sys_rst_n_s),
      .wr_en  (bus_wr),
      .wr_addr(bus_addr),
      .wr_data(bus_wdata),
      .q      (gen_q[gi]),
      .locked (gen_lock[gi])
    );
  end

  logic lv_q;
  logic lv_lock;

  cfg_por_bit #(
    .ADDR_W(ADDR_W),
    .ADDR  (REG1_ADDR)
  ) u_lv_bit (
    .clk      (clk),
    .por_rst_n(por_rst_n_s),
    .wr_en    (bus_wr),
    .wr_addr  (bus_addr),
    .wr_bit   (bus_wdata[LV_BIT]),
    .q        (lv_q),
    .locked   (lv_lock)
  );

  logic [DATA_W-1:0] reg1_view;
  logic [DATA_W-1:0] reg2_view;

  always_comb begin
    reg1_view         = gen_q[0];
    reg1_view[LV_BIT] = lv_q;
    reg2_view         = gen_q[1];
  end

  always_comb begin
    unique case (bus_addr)
      REG1_ADDR: bus_rdata = reg1_view;
      REG2_ADDR: bus_rdata = reg2_view;
      default:   bus_rdata = '0;
    endcase
  end

  assign wdog_rate      = reg1_view[7];
  assign lv_in_stop     = reg1_view[6];
  assign lv_rst_off     = reg1_view[5];
  assign lv_pwr_off     = reg1_view[4];
  assign lv_sel         = reg1_view[LV_BIT];
  assign quick_stop_rec = reg1_view[2];
  assign stop_ok        = reg1_view[1];
  assign wdog_off       = reg1_view[0];
  assign xtal_en        = reg2_view[XTAL_BIT];
  assign ext_slow       = reg2_view[SLOW_BIT];
  assign ext_clk_en     = reg2_view[EXTC_BIT];
  assign osc_in_stop    = reg2_view[OSCS_BIT];
  assign osc2_gpio      = ~reg2_view[XTAL_BIT];

  // R2: first write to register 1 appears on the outputs next cycle
  p_wr_first_r2: assert property (@(posedge clk) disable iff (!sys_rst_n_s)
    (bus_wr && bus_addr == REG1_ADDR && !gen_lock[0]) |=>
      (wdog_off == $past(bus_wdata[0]) && wdog_rate == $past(bus_wdata[7])));

  // R10: strobes elsewhere leave both registers untouched
  p_other_wr_r10: assert property (@(posedge clk) disable iff (!sys_rst_n_s)
    (bus_wr && bus_addr != REG1_ADDR && bus_addr != REG2_ADDR) |=>
      ($stable(gen_q[0]) && $stable(gen_q[1]) && $stable(lv_q)));

  // R6: the ordinary reset domain never touches the power-on bit
  p_lv_keep_r6: assert property (@(posedge clk) disable iff (!por_rst_n_s)
    !sys_rst_n_s |=> $stable(lv_q));
endmodule

// File: tb/cfg_once_regs_bench.sv
module cfg_once_regs_bench;
  logic       clk;
  logic       por_n;
  logic       rst_n;
  logic [7:0] bus_addr;
  logic       bus_wr;
  logic [7:0] bus_wdata;
  logic [7:0] bus_rdata;
  logic wdog_rate, lv_in_stop, lv_rst_off, lv_pwr_off, lv_sel, quick_stop_rec;
  logic stop_ok, wdog_off, xtal_en, ext_slow, ext_clk_en, osc_in_stop, osc2_gpio;

  int n_chk;
  int n_bad;
  bit done;

  cfg_once_regs u_cfg_once_regs (
    .clk(clk), .por_n(por_n), .rst_n(rst_n),
    .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata),
    .wdog_rate(wdog_rate), .lv_in_stop(lv_in_stop), .lv_rst_off(lv_rst_off),
    .lv_pwr_off(lv_pwr_off), .lv_sel(lv_sel), .quick_stop_rec(quick_stop_rec),
    .stop_ok(stop_ok), .wdog_off(wdog_off), .xtal_en(xtal_en),
    .ext_slow(ext_slow), .ext_clk_en(ext_clk_en), .osc_in_stop(osc_in_stop),
    .osc2_gpio(osc2_gpio)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  function automatic logic [7:0] out1();
    return {wdog_rate, lv_in_stop, lv_rst_off, lv_pwr_off,
            lv_sel, quick_stop_rec, stop_ok, wdog_off};
  endfunction

  function automatic logic [7:0] out2();
    return {1'b0, xtal_en, ext_slow, ext_clk_en, 2'b00, osc_in_stop, 1'b0};
  endfunction

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr  = a;
    bus_wdata = d;
    bus_wr    = 1'b1;
    @(negedge clk);
    bus_wr    = 1'b0;
  endtask

  task automatic do_por();
    @(negedge clk);
    por_n = 1'b0;
    rst_n = 1'b0;
    @(negedge clk);
    por_n = 1'b1;
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic do_rst();
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    logic [7:0] d;
    n_chk = 0;
    n_bad = 0;
    done = 1'b0;
    por_n = 1'b0;
    rst_n = 1'b0;
    bus_addr = 8'h00;
    bus_wr = 1'b0;
    bus_wdata = 8'h00;
    do_por();

    // R1: reset state
    rd(8'h1F, d); chk("R1 reg1", d, 8'h00);
    rd(8'h1E, d); chk("R1 reg2", d, 8'h00);
    chk("R1 outputs", {out1()}, 8'h00);
    chk("R1 gpio", {7'd0, osc2_gpio}, 8'h01);

    // R8: address held without strobe consumes nothing
    @(negedge clk); bus_addr = 8'h1F; repeat (4) @(negedge clk);
    wr(8'h1F, 8'hA5);
    rd(8'h1F, d); chk("R8 no-strobe keeps reg1 open", d, 8'hA5);

    for (int v = 0; v < 256; v++) begin
      logic [7:0] b;
      b = v[7:0];
      do_por();
      // R7: power-on reset clears the low-voltage bit
      rd(8'h1F, d); chk("R7 por clears reg1", d, 8'h00);
      wr(8'h1F, b);
      rd(8'h1F, d); chk("R2 first write reg1", d, b);
      chk("R2 reg1 outputs", out1(), b);
      wr(8'h1F, ~b);
      rd(8'h1F, d); chk("R4 reg1 locked", d, b);
      wr(8'h1E, b);
      rd(8'h1E, d); chk("R3 first write reg2", d, b & 8'h72);
      chk("R3 reg2 outputs", out2(), b & 8'h72);
      chk("R9 gpio", {7'd0, osc2_gpio}, {7'd0, ~b[6]});
      wr(8'h1E, ~b);
      rd(8'h1E, d); chk("R4 reg2 locked", d, b & 8'h72);
      do_rst();
      rd(8'h1F, d); chk("R5 R6 reg1 after reset", d, b & 8'h08);
      rd(8'h1E, d); chk("R5 reg2 after reset", d, 8'h00);
      wr(8'h1F, ~b);
      rd(8'h1F, d); chk("R5 R6 reg1 rewrite", d, (~b & 8'hF7) | (b & 8'h08));
      wr(8'h1E, ~b);
      rd(8'h1E, d); chk("R5 reg2 rewrite", d, ~b & 8'h72);
      chk("R9 gpio rewrite", {7'd0, osc2_gpio}, {7'd0, b[6]});
    end

    // R6: unwritten power-on bit survives an ordinary reset still open
    do_por();
    wr(8'h1E, 8'hFF);
    do_rst();
    wr(8'h1F, 8'hFF);
    rd(8'h1F, d); chk("R6 lv still open", d, 8'hFF);
    do_rst();
    wr(8'h1F, 8'h00);
    rd(8'h1F, d); chk("R6 lv kept closed", d, 8'h08);

    // R8 and R10: every other address
    do_por();
    for (int a = 0; a < 256; a++) begin
      if (a != 8'h1E && a != 8'h1F) begin
        rd(a[7:0], d); chk("R8 other read", d, 8'h00);
        wr(a[7:0], 8'hFF);
        rd(a[7:0], d); chk("R8 other read after write", d, 8'h00);
      end
    end
    rd(8'h1F, d); chk("R10 reg1 untouched", d, 8'h00);
    rd(8'h1E, d); chk("R10 reg2 untouched", d, 8'h00);
    wr(8'h1F, 8'h5A);
    rd(8'h1F, d); chk("R10 reg1 still open", d, 8'h5A);
    wr(8'h1E, 8'h5A);
    rd(8'h1E, d); chk("R10 reg2 still open", d, 8'h52);

    // R11: asynchronous clear
    @(negedge clk);
    #1 rst_n = 1'b0;
    #0.5;
    chk("R11 reg1 cleared at once", out1(), 8'h08);
    chk("R11 reg2 cleared at once", out2(), 8'h00);
    @(negedge clk);
    rst_n = 1'b1;
    #1 por_n = 1'b0;
    #0.5;
    chk("R11 por clears lv at once", out1(), 8'h00);
    @(negedge clk);
    por_n = 1'b1;
    repeat (3) @(negedge clk);

    done = 1'b1;
  end

  initial begin
    fork
      begin
        wait (done);
      end
      begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule